// File: doc/BRIEF.md
# Reservation Station Pool with Register Renaming

This block keeps a small pool of reservation stations for one class of ALU operations, together with a register table. Each register in the table holds either a committed value or the tag of the station that will produce its next value. Instructions arrive in program order on a valid/ready issue port. The issue port accepts a request only while a station is free. If no station is free, `iss_ready` stays low and the request at the head of the queue waits unchanged. Back-pressure on this port is the only way the pool slows the instruction queue.

At issue, each source operand is resolved. A register with no pending producer supplies its value, and a register with a pending producer supplies that producer's tag. The destination register is then renamed to the new station's tag. Waiting stations watch the common data bus (CDB) and take a value when its tag matches. A station whose two operands are both present is offered to the functional unit on a valid/ready dispatch port. Once `fu_valid` is high, the offer (tag, opcode and operands) stays fixed until `fu_ready` accepts it. Results come back from the functional unit on `res_*`, one per cycle, and are always accepted. The block registers each result and drives it onto the CDB output.

Tags are station index plus one, so tags run from 1 to the station count and tag 0 means "no producer".

Top module: `rs_pool`

## Requirements
- R1: After reset, every station is free, `iss_ready` is 1, `fu_valid` and `cdb_valid` are 0, and every register has no pending producer and holds the value 0.
- R2: An issue request is taken on a cycle with `iss_valid` and `iss_ready` both high. `iss_ready` is low exactly when all stations are occupied. While it is low, a held request is not taken and does not reach the functional unit.
- R3: An accepted instruction goes into the lowest-index free station. Its tag, seen on `fu_tag`, is the station index plus 1, so tag 0 never appears on dispatch.
- R4: At issue, a source register with no pending producer has its current value copied into the station.
- R5: At issue, the destination register's producer tag is overwritten with the new station's tag. Later readers of that register wait for the newest producer, not an older one.
- R6: A station waiting on a tag takes the CDB value when the broadcast tag matches. This also holds for an operand whose producer is broadcast in the same cycle the instruction is issued.
- R7: A station is offered on the dispatch port only when both operands hold values. While `fu_valid` is high and `fu_ready` is low, `fu_tag`, `fu_op`, `fu_a` and `fu_b` hold steady.
- R8: When no offer is pending and several stations are ready, the lowest-index ready station is offered first.
- R9: A result presented with `res_valid` appears on the CDB one cycle later with the same tag and value. With no result presented, `cdb_valid` is 0 in the next cycle.
- R10: A broadcast writes its value into a register, and clears that register's pending state, only if the register's producer tag still equals the broadcast tag.
- R11: A station whose tag is broadcast becomes free in the following cycle. When the pool was full, `iss_ready` rises one cycle after the CDB broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | A station is free; request taken when both high |
| iss_op | input | OP_W | Operation code carried to the functional unit |
| iss_dst | input | log2(NUM_REGS) | Destination register |
| iss_src1 | input | log2(NUM_REGS) | First source register |
| iss_src2 | input | log2(NUM_REGS) | Second source register |
| fu_valid | output | 1 | Dispatch offer valid |
| fu_ready | input | 1 | Functional unit accepts the offer |
| fu_tag | output | TAG_W | Tag of the offered station |
| fu_op | output | OP_W | Operation code of the offered station |
| fu_a | output | DATA_W | First operand value |
| fu_b | output | DATA_W | Second operand value |
| res_valid | input | 1 | Result from the functional unit valid |
| res_tag | input | TAG_W | Tag of the result |
| res_value | input | DATA_W | Result value |
| cdb_valid | output | 1 | CDB broadcast valid |
| cdb_tag | output | TAG_W | CDB producer tag |
| cdb_value | output | DATA_W | CDB value |

## Verification
The assertions check the port rules on every cycle:
- the CDB follows the result port by one cycle;
- a pending dispatch offer stays stable;
- an offered tag is never 0 and never above the station count;
- the offered station really has both operands;
- after any broadcast, a station is free to accept issue.

Only the directed scenarios can show the data-dependent behaviour:
- renaming, where a stale broadcast must leave a renamed register pending;
- same-cycle capture of a value being broadcast during issue;
- lowest-index ordering;
- stalling of a held request while the pool is full.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
  typedef enum logic [1:0] {
    RS_FREE = 2'd0,
    RS_WAIT = 2'd1,
    RS_EXEC = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rs_pick.sv
// Lowest-index picker over a request vector.
module rs_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rs_regstat.sv
// Register values plus producer tags, with CDB bypass on the read ports.
module rs_regstat #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  rd_idx  [2],
  output logic [DATA_W-1:0] rd_val  [2],
  output logic [TAG_W-1:0]  rd_tag  [2],
  input  logic              ren_en,
  input  logic [REG_W-1:0]  ren_idx,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value
);
  logic [DATA_W-1:0] reg_val [NUM_REGS];
  logic [TAG_W-1:0]  reg_tag [NUM_REGS];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [TAG_W-1:0] raw_tag;
    logic             hit;
    always_comb begin
      raw_tag = reg_tag[rd_idx[p]];
      hit     = (raw_tag != '0) && cdb_valid && (cdb_tag == raw_tag);
      if (hit) begin
        rd_val[p] = cdb_value;
        rd_tag[p] = '0;
      end else if (raw_tag == '0) begin
        rd_val[p] = reg_val[rd_idx[p]];
        rd_tag[p] = '0;
      end else begin
        rd_val[p] = '0;
        rd_tag[p] = raw_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        reg_val[r] <= '0;
        reg_tag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (ren_en && ren_idx == REG_W'(r)) begin
          reg_tag[r] <= ren_tag;
        end else if (cdb_valid && reg_tag[r] != '0 && reg_tag[r] == cdb_tag) begin
          reg_val[r] <= cdb_value;
          reg_tag[r] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rs_station.sv
// One reservation station entry.
module rs_station
  import rs_pool_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   a_op,
  input  logic [DATA_W-1:0] a_v1,
  input  logic [TAG_W-1:0]  a_q1,
  input  logic [DATA_W-1:0] a_v2,
  input  logic [TAG_W-1:0]  a_q2,
  input  logic              grant,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              is_free,
  output logic              is_ready,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] v1_o,
  output logic [DATA_W-1:0] v2_o
);
  rs_state_e         state;
  logic [TAG_W-1:0]  q1, q2;

  assign is_free  = (state == RS_FREE);
  assign is_ready = (state == RS_WAIT) && (q1 == '0) && (q2 == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RS_FREE;
      op_o  <= '0;
      v1_o  <= '0;
      v2_o  <= '0;
      q1    <= '0;
      q2    <= '0;
    end else begin
      case (state)
        RS_FREE: begin
          if (alloc) begin
            state <= RS_WAIT;
            op_o  <= a_op;
            v1_o  <= a_v1;
            q1    <= a_q1;
            v2_o  <= a_v2;
            q2    <= a_q2;
          end
        end
        RS_WAIT: begin
          if (q1 != '0 && cdb_valid && cdb_tag == q1) begin
            v1_o <= cdb_value;
            q1   <= '0;
          end
          if (q2 != '0 && cdb_valid && cdb_tag == q2) begin
            v2_o <= cdb_value;
            q2   <= '0;
          end
          if (grant) state <= RS_EXEC;
        end
        RS_EXEC: begin
          if (cdb_valid && cdb_tag == MY_TAG) state <= RS_FREE;
        end
        default: state <= RS_FREE;
      endcase
    end
  end
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int NUM_RS   = 4,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 4,
  localparam int TAG_W   = $clog2(NUM_RS + 1),
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [REG_W-1:0]  iss_src1,
  input  logic [REG_W-1:0]  iss_src2,
  output logic              fu_valid,
  input  logic              fu_ready,
  output logic [TAG_W-1:0]  fu_tag,
  output logic [OP_W-1:0]   fu_op,
  output logic [DATA_W-1:0] fu_a,
  output logic [DATA_W-1:0] fu_b,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_value
);
  logic [NUM_RS-1:0] st_free, st_rdy, st_alloc, st_grant;
  logic [OP_W-1:0]   st_op [NUM_RS];
  logic [DATA_W-1:0] st_v1 [NUM_RS];
  logic [DATA_W-1:0] st_v2 [NUM_RS];

  logic              any_free, any_rdy, iss_fire;
  logic [IDX_W-1:0]  free_idx, rdy_idx, sel_idx, hold_idx_q;
  logic              hold_q;
  logic [TAG_W-1:0]  new_tag;

  logic [REG_W-1:0]  rd_idx [2];
  logic [DATA_W-1:0] rd_val [2];
  logic [TAG_W-1:0]  rd_tag [2];

  // CDB stage: results are registered, then broadcast
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cdb_valid <= 1'b0;
      cdb_tag   <= '0;
      cdb_value <= '0;
    end else begin
      cdb_valid <= res_valid;
      if (res_valid) begin
        cdb_tag   <= res_tag;
        cdb_value <= res_value;
      end
    end
  end

  // Issue side
  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_free_pick (
    .req(st_free), .found(any_free), .idx(free_idx)
  );

  assign iss_ready = any_free;
  assign iss_fire  = iss_valid && any_free;
  assign new_tag   = TAG_W'(free_idx) + TAG_W'(1);
  assign rd_idx[0] = iss_src1;
  assign rd_idx[1] = iss_src2;

  rs_regstat #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_regstat (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_val(rd_val), .rd_tag(rd_tag),
    .ren_en(iss_fire), .ren_idx(iss_dst), .ren_tag(new_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  // Station array
  for (genvar g = 0; g < NUM_RS; g++) begin : g_st
    assign st_alloc[g] = iss_fire && (free_idx == IDX_W'(g));
    assign st_grant[g] = fu_valid && fu_ready && (sel_idx == IDX_W'(g));

    rs_station #(
      .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W),
      .MY_TAG(TAG_W'(g + 1))
    ) u_st (
      .clk(clk), .rst_n(rst_n),
      .alloc(st_alloc[g]), .a_op(iss_op),
      .a_v1(rd_val[0]), .a_q1(rd_tag[0]),
      .a_v2(rd_val[1]), .a_q2(rd_tag[1]),
      .grant(st_grant[g]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .is_free(st_free[g]), .is_ready(st_rdy[g]),
      .op_o(st_op[g]), .v1_o(st_v1[g]), .v2_o(st_v2[g])
    );
  end

  // Dispatch side: lowest ready index, locked while the offer waits
  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_rdy_pick (
    .req(st_rdy), .found(any_rdy), .idx(rdy_idx)
  );

  assign sel_idx  = hold_q ? hold_idx_q : rdy_idx;
  assign fu_valid = hold_q || any_rdy;
  assign fu_tag   = TAG_W'(sel_idx) + TAG_W'(1);
  assign fu_op    = st_op[sel_idx];
  assign fu_a     = st_v1[sel_idx];
  assign fu_b     = st_v2[sel_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= fu_valid && !fu_ready;
      hold_idx_q <= sel_idx;
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int NUM_RS = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_ready,
  input logic              fu_valid,
  input logic              fu_ready,
  input logic [TAG_W-1:0]  fu_tag,
  input logic [OP_W-1:0]   fu_op,
  input logic [DATA_W-1:0] fu_a,
  input logic [DATA_W-1:0] fu_b,
  input logic              res_valid,
  input logic [TAG_W-1:0]  res_tag,
  input logic [DATA_W-1:0] res_value,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic [DATA_W-1:0] cdb_value,
  input logic [NUM_RS-1:0] st_rdy
);
  logic offered_rdy;
  always_comb begin
    offered_rdy = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (fu_tag == TAG_W'(i + 1)) offered_rdy = st_rdy[i];
    end
  end

  p_cdb_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> cdb_valid && cdb_tag == $past(res_tag) && cdb_value == $past(res_value));

  p_cdb_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> !cdb_valid);

  p_offer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid && !fu_ready |=> fu_valid && $stable(fu_tag) && $stable(fu_op)
                              && $stable(fu_a) && $stable(fu_b));

  p_offer_operands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid |-> offered_rdy);

  p_tag_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid |-> fu_tag != '0 && fu_tag <= TAG_W'(NUM_RS));

  p_freed_after_bcast_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid && cdb_tag != '0 |=> iss_ready);
endmodule

bind rs_pool rs_pool_chk #(
  .NUM_RS(NUM_RS), .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_ready(iss_ready),
  .fu_valid(fu_valid), .fu_ready(fu_ready), .fu_tag(fu_tag), .fu_op(fu_op),
  .fu_a(fu_a), .fu_b(fu_b),
  .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
  .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
  .st_rdy(st_rdy)
);

// File: tb/test_rs_pool.sv
module test_rs_pool;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [3:0]  iss_op = '0;
  logic [2:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic        fu_valid;
  logic        fu_ready = 1'b0;
  logic [2:0]  fu_tag;
  logic [3:0]  fu_op;
  logic [31:0] fu_a, fu_b;
  logic        res_valid = 1'b0;
  logic [2:0]  res_tag = '0;
  logic [31:0] res_value = '0;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [31:0] cdb_value;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rs_pool i_rs_pool (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .fu_valid(fu_valid), .fu_ready(fu_ready), .fu_tag(fu_tag), .fu_op(fu_op),
    .fu_a(fu_a), .fu_b(fu_b),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_issue(input logic [3:0] op, input logic [2:0] dst, input logic [2:0] s1, input logic [2:0] s2);
    iss_valid = 1'b1; iss_op = op; iss_dst = dst; iss_src1 = s1; iss_src2 = s2;
    chk(iss_ready === 1'b1, "R2 issue ready", 32'(iss_ready), 1);
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic take(input logic [2:0] tag, input logic [31:0] a, input logic [31:0] b, input string req);
    chk(fu_valid === 1'b1, {req, " fu_valid"}, 32'(fu_valid), 1);
    chk(fu_tag === tag, {req, " fu_tag"}, 32'(fu_tag), 32'(tag));
    chk(fu_a === a, {req, " fu_a"}, fu_a, a);
    chk(fu_b === b, {req, " fu_b"}, fu_b, b);
    fu_ready = 1'b1;
    tick();
    fu_ready = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] tag, input logic [31:0] val);
    res_valid = 1'b1; res_tag = tag; res_value = val;
    tick();
    chk(cdb_valid === 1'b1 && cdb_tag === tag && cdb_value === val, "R9 cdb follows result",
        cdb_value, val);
    res_valid = 1'b0;
    tick();
    chk(cdb_valid === 1'b0, "R9 cdb idle", 32'(cdb_valid), 0);
  endtask

  // R1: reset values, then a first instruction reads zero registers
  task automatic t_reset();
    chk(iss_ready === 1'b1, "R1 iss_ready", 32'(iss_ready), 1);
    chk(fu_valid === 1'b0, "R1 fu_valid", 32'(fu_valid), 0);
    chk(cdb_valid === 1'b0, "R1 cdb_valid", 32'(cdb_valid), 0);
    do_issue(4'd1, 3'd1, 3'd7, 3'd4);
    chk(fu_op === 4'd1, "R1 op", 32'(fu_op), 1);
    take(3'd1, 32'h0, 32'h0, "R1 zero regs");
    bcast(3'd1, 32'h11);
  endtask

  // R4, R10: broadcast value lands in register and is read at issue
  task automatic t_basic();
    do_issue(4'd2, 3'd2, 3'd1, 3'd0);
    chk(fu_op === 4'd2, "R4 op", 32'(fu_op), 2);
    take(3'd1, 32'h11, 32'h0, "R4 read value");
    bcast(3'd1, 32'h22);
  endtask

  // R5, R7, R8, R10, R6: rename, stale broadcast, wait, capture
  task automatic t_rename();
    do_issue(4'd3, 3'd3, 3'd1, 3'd2);
    do_issue(4'd4, 3'd3, 3'd0, 3'd0);
    chk(fu_tag === 3'd1, "R8 lowest first", 32'(fu_tag), 1);
    tick();
    chk(fu_valid === 1'b1 && fu_tag === 3'd1 && fu_a === 32'h11, "R7 offer held",
        32'(fu_tag), 1);
    take(3'd1, 32'h11, 32'h22, "R8 tag1");
    take(3'd2, 32'h0, 32'h0, "R8 tag2");
    bcast(3'd1, 32'hAAAA);
    do_issue(4'd5, 3'd4, 3'd3, 3'd2);
    chk(fu_valid === 1'b0, "R10 R5 stale bcast leaves r3 pending", 32'(fu_valid), 0);
    tick();
    chk(fu_valid === 1'b0, "R7 wait for operand", 32'(fu_valid), 0);
    bcast(3'd2, 32'hBBBB);
    take(3'd1, 32'hBBBB, 32'h22, "R6 captured");
    do_issue(4'd6, 3'd5, 3'd3, 3'd3);
    take(3'd2, 32'hBBBB, 32'hBBBB, "R10 newest written");
    bcast(3'd1, 32'hCCCC);
    bcast(3'd2, 32'hDDDD);
  endtask

  // R6: operand broadcast during the issue cycle is captured
  task automatic t_same_cycle();
    do_issue(4'd7, 3'd5, 3'd0, 3'd0);
    take(3'd1, 32'h0, 32'h0, "R6 producer");
    res_valid = 1'b1; res_tag = 3'd1; res_value = 32'h55;
    tick();
    res_valid = 1'b0;
    do_issue(4'd8, 3'd6, 3'd5, 3'd5);
    take(3'd2, 32'h55, 32'h55, "R6 same-cycle snoop");
    bcast(3'd2, 32'h66);
  endtask

  // R2, R3, R8, R11: fill the pool, stall, free one, resume
  task automatic t_full();
    for (int i = 0; i < 4; i++) do_issue(4'(i), 3'd7, 3'd0, 3'd0);
    chk(iss_ready === 1'b0, "R2 full", 32'(iss_ready), 0);
    iss_valid = 1'b1; iss_op = 4'd9; iss_dst = 3'd6; iss_src1 = 3'd2; iss_src2 = 3'd2;
    tick();
    chk(iss_ready === 1'b0, "R2 still full", 32'(iss_ready), 0);
    for (int i = 1; i <= 4; i++) take(3'(i), 32'h0, 32'h0, "R3 R8 in order");
    chk(fu_valid === 1'b0, "R2 stalled request not taken", 32'(fu_valid), 0);
    res_valid = 1'b1; res_tag = 3'd3; res_value = 32'h33;
    tick();
    res_valid = 1'b0;
    chk(iss_ready === 1'b0, "R11 not yet free", 32'(iss_ready), 0);
    tick();
    chk(iss_ready === 1'b1, "R11 freed", 32'(iss_ready), 1);
    tick();
    iss_valid = 1'b0;
    chk(fu_op === 4'd9, "R3 reuse station", 32'(fu_op), 9);
    take(3'd3, 32'h22, 32'h22, "R3 freed slot");
    bcast(3'd1, 32'h1);
    bcast(3'd2, 32'h2);
    bcast(3'd4, 32'h4);
    bcast(3'd3, 32'h3);
    chk(iss_ready === 1'b1 && fu_valid === 1'b0, "R11 drained", 32'(iss_ready), 1);
    do_issue(4'd10, 3'd0, 3'd7, 3'd6);
    take(3'd1, 32'h4, 32'h3, "R10 last rename wins");
    bcast(3'd1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_rename();
    t_same_cycle();
    t_full();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule